// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Zero, Subtract, Half-Carry and Carry Flags

This block performs one 8-bit arithmetic or logic operation per clock. It takes a primary operand (the accumulator value), a secondary operand, the current four-bit flag nibble and a 4-bit operation code. It returns the 8-bit result, the complete new flag nibble and a 4-bit write mask.

Flags that the operation does not touch are passed through unchanged from the incoming nibble. The mask still tells the caller which flag bits the operation defines. Outputs are registered, so a result appears one clock after its inputs are presented. A synchronous active-high reset clears all outputs.

The flag nibble is ordered Z (bit 3), N (bit 2), H (bit 1), C (bit 0). The write mask uses the same bit positions. H is the carry or borrow across the nibble boundary, between bit 3 and bit 4. C is the carry or borrow out of bit 7.

Operation codes:

| Code | Operation | Result |
|------|-----------|--------|
| 0 | add | A + B |
| 1 | add with carry | A + B + C |
| 2 | subtract | A − B |
| 3 | subtract with borrow | A − B − C |
| 4 | and | A AND B |
| 5 | or | A OR B |
| 6 | xor | A XOR B |
| 7 | compare | flags from A − B |
| 8 | increment | B + 1 |
| 9 | decrement | B − 1 |
| 10 | decimal adjust | A corrected to packed BCD |
| 11 | complement | NOT A |
| 12 | set carry | A |
| 13 | invert carry | A |
| 14, 15 | pass | A |

Top module: `alu8`

## Requirements
- R1: Codes 0 and 1 return A+B (plus incoming C for code 1). Z is set when the result is zero, N is 0, H is the carry out of bit 3, and C is the carry out of bit 7. The mask is 1111.
- R2: Codes 2 and 3 return A−B (minus incoming C for code 3). Z is set from the result, N is 1, H is the borrow from bit 4, and C is the borrow past bit 7. The mask is 1111.
- R3: Code 7 produces the same flags as code 2 but returns A unchanged as the result.
- R4: Code 4 gives flags Z,0,1,0. Codes 5 and 6 give flags Z,0,0,0. Z reflects the logic result, and the mask is 1111.
- R5: Codes 8 and 9 return B+1 and B−1. Z is set from the result, N is 0 for code 8 and 1 for code 9, and H is the nibble carry or borrow. C keeps its incoming value, and the mask is 1110.
- R6: Code 10 adjusts A to packed BCD. When incoming N=0 it adds 0x06 if H is set or the low nibble exceeds 9, and adds 0x60 if C is set or A exceeds 0x99. When N=1 it subtracts 0x06 if H is set and 0x60 if C is set. Z comes from the result, H becomes 0, N is kept, and C is set when the 0x60 correction applies. The mask is 1011.
- R7: Code 11 returns the bitwise inverse of A, sets N=1 and H=1, and keeps Z and C. The mask is 0110.
- R8: Code 12 sets C=1. Code 13 inverts C. Both clear N and H, keep Z, return A, and use mask 0111.
- R9: Every flag bit whose mask bit is 0 equals the corresponding bit of the incoming flag nibble.
- R10: Result, flags and mask are registered with one clock of latency. While reset is high they are all zero at the next edge.
- R11: Codes 14 and 15 return A, pass the incoming flags through, and use mask 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | Primary operand (accumulator) |
| opb_i | input | 8 | Secondary operand |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| res_o | output | 8 | Registered result |
| flags_o | output | 4 | Registered new flags {Z,N,H,C} |
| wmask_o | output | 4 | Registered flag write mask {Z,N,H,C} |

## Verification
Several properties are checked by assertions on every cycle:
- masked-off flags equal the previous cycle's incoming flags;
- compare returns the prior primary operand;
- increment and decrement keep C;
- N is set after every subtract-type code;
- Z agrees with a zero result for every code that derives Z from the result.

The exact arithmetic values come only from the bench's directed scenarios. These include the nibble carry and borrow, the carry and borrow out of bit 7, the two decimal-adjust directions and the carry-set and carry-invert outcomes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_DAA  = 4'd10,
    OP_CPL  = 4'd11,
    OP_SCF  = 4'd12,
    OP_CCF  = 4'd13,
    OP_PASS = 4'd14
  } alu_op_e;

  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;
  localparam int NFLAGS = 4;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_kind_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] r_o,
  output logic          hc_o,
  output logic          cy_o
);
  localparam int NB = DW / 2;

  logic [DW:0] wide;
  logic [NB:0] low;

  always_comb begin
    if (!sub_i) begin
      wide = {1'b0, x_i} + {1'b0, y_i} + {{DW{1'b0}}, cin_i};
      low  = {1'b0, x_i[NB-1:0]} + {1'b0, y_i[NB-1:0]} + {{NB{1'b0}}, cin_i};
    end else begin
      // A negative difference wraps and sets the top bit, which is the borrow.
      wide = {1'b0, x_i} - {1'b0, y_i} - {{DW{1'b0}}, cin_i};
      low  = {1'b0, x_i[NB-1:0]} - {1'b0, y_i[NB-1:0]} - {{NB{1'b0}}, cin_i};
    end
  end

  assign r_o  = wide[DW-1:0];
  assign cy_o = wide[DW];
  assign hc_o = low[NB];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  alu8_pkg::logic_kind_e kind_i,
  input  logic [DW-1:0]         x_i,
  input  logic [DW-1:0]         y_i,
  output logic [DW-1:0]         r_o
);
  import alu8_pkg::*;

  always_comb begin
    unique case (kind_i)
      LG_AND:  r_o = x_i & y_i;
      LG_OR:   r_o = x_i | y_i;
      default: r_o = x_i ^ y_i;
    endcase
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          n_i,
  input  logic          h_i,
  input  logic          c_i,
  output logic [DW-1:0] r_o,
  output logic          c_o
);
  localparam int NB = DW / 2;
  localparam logic [DW-1:0] LO_ADJ = DW'(6);
  localparam logic [DW-1:0] HI_ADJ = DW'(6) << NB;
  localparam logic [DW-1:0] HI_LIM = DW'(9) | (DW'(9) << NB);

  logic          lo_fix;
  logic          hi_fix;
  logic [DW-1:0] adj;

  always_comb begin
    lo_fix = h_i || (!n_i && (a_i[NB-1:0] > NB'(9)));
    hi_fix = c_i || (!n_i && (a_i > HI_LIM));
    adj    = (hi_fix ? HI_ADJ : '0) | (lo_fix ? LO_ADJ : '0);
    r_o    = n_i ? (a_i - adj) : (a_i + adj);
    c_o    = hi_fix;
  end
endmodule

// File: rtl/alu8.sv
module alu8 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [3:0]    flags_i,
  output logic [DW-1:0] res_o,
  output logic [3:0]    flags_o,
  output logic [3:0]    wmask_o
);
  import alu8_pkg::*;

  alu_op_e     op;
  logic [DW-1:0] as_x, as_y, as_r, lg_r, daa_r, res_nxt;
  logic          as_cin, as_sub, as_hc, as_cy, daa_c;
  logic_kind_e   lg_kind;
  logic [NFLAGS-1:0] calc, mask, merged;

  assign op = alu_op_e'(op_i);

  // Operand steering for the shared adder/subtractor.
  always_comb begin
    as_x   = ((op == OP_INC) || (op == OP_DEC)) ? opb_i : opa_i;
    as_y   = ((op == OP_INC) || (op == OP_DEC)) ? DW'(1) : opb_i;
    as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? flags_i[FC] : 1'b0;
    as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
    lg_kind = (op == OP_AND) ? LG_AND : ((op == OP_OR) ? LG_OR : LG_XOR);
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .x_i(as_x), .y_i(as_y), .cin_i(as_cin), .sub_i(as_sub),
    .r_o(as_r), .hc_o(as_hc), .cy_o(as_cy)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .kind_i(lg_kind), .x_i(opa_i), .y_i(opb_i), .r_o(lg_r)
  );

  alu8_daa #(.DW(DW)) u_daa (
    .a_i(opa_i), .n_i(flags_i[FN]), .h_i(flags_i[FH]), .c_i(flags_i[FC]),
    .r_o(daa_r), .c_o(daa_c)
  );

  // Per-operation result and flag policy, as {Z,N,H,C}.
  always_comb begin
    res_nxt = opa_i;
    calc    = '0;
    mask    = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        res_nxt = as_r;
        calc = {as_r == '0, 1'b0, as_hc, as_cy};
        mask = 4'b1111;
      end
      OP_SUB, OP_SBC: begin
        res_nxt = as_r;
        calc = {as_r == '0, 1'b1, as_hc, as_cy};
        mask = 4'b1111;
      end
      OP_CMP: begin
        calc = {as_r == '0, 1'b1, as_hc, as_cy};
        mask = 4'b1111;
      end
      OP_AND: begin
        res_nxt = lg_r;
        calc = {lg_r == '0, 1'b0, 1'b1, 1'b0};
        mask = 4'b1111;
      end
      OP_OR, OP_XOR: begin
        res_nxt = lg_r;
        calc = {lg_r == '0, 3'b000};
        mask = 4'b1111;
      end
      OP_INC: begin
        res_nxt = as_r;
        calc = {as_r == '0, 1'b0, as_hc, 1'b0};
        mask = 4'b1110;
      end
      OP_DEC: begin
        res_nxt = as_r;
        calc = {as_r == '0, 1'b1, as_hc, 1'b0};
        mask = 4'b1110;
      end
      OP_DAA: begin
        res_nxt = daa_r;
        calc = {daa_r == '0, 1'b0, 1'b0, daa_c};
        mask = 4'b1011;
      end
      OP_CPL: begin
        res_nxt = ~opa_i;
        calc = 4'b0110;
        mask = 4'b0110;
      end
      OP_SCF: begin
        calc = 4'b0001;
        mask = 4'b0111;
      end
      OP_CCF: begin
        calc = {3'b000, ~flags_i[FC]};
        mask = 4'b0111;
      end
      default: begin
        calc = '0;
        mask = '0;
      end
    endcase
  end

  // Merge computed flags with the incoming nibble, bit by bit.
  for (genvar i = 0; i < NFLAGS; i++) begin : g_merge
    assign merged[i] = mask[i] ? calc[i] : flags_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
      wmask_o <= '0;
    end else begin
      res_o   <= res_nxt;
      flags_o <= merged;
      wmask_o <= mask;
    end
  end

  // R9: flags outside the mask carry the incoming values.
  a_r9_masked_pass: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((flags_o ^ $past(flags_i)) & ~wmask_o) == 4'b0000));

  // R3: compare leaves the primary operand as result.
  a_r3_cmp_keeps_a: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 4'd7) |-> (res_o == $past(opa_i)));

  // R5: increment and decrement keep C.
  a_r5_keep_carry: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == 4'd8 || $past(op_i) == 4'd9))
      |-> (flags_o[0] == $past(flags_i[0]) && !wmask_o[0]));

  // R2: subtract-type codes report N=1.
  a_r2_sub_sets_n: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == 4'd2 || $past(op_i) == 4'd3 || $past(op_i) == 4'd7))
      |-> flags_o[2]);

  // R1: Z agrees with the stored result for result-driven codes.
  a_r1_zero_matches: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) <= 4'd10) && ($past(op_i) != 4'd7))
      |-> (flags_o[3] == (res_o == '0)));
endmodule

// File: tb/alu8_tb.sv
module alu8_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = 4'd0;
  logic [7:0] opa_i = 8'd0, opb_i = 8'd0;
  logic [3:0] flags_i = 4'd0;
  logic [7:0] res_o;
  logic [3:0] flags_o, wmask_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  alu8 u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o), .wmask_o(wmask_o)
  );

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] fi, input logic [7:0] er, input logic [3:0] ef,
                        input logic [3:0] em, input string tag);
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; flags_i = fi;
    @(posedge clk);
    #1;
    total++;
    if (res_o !== er || flags_o !== ef || wmask_o !== em) begin
      bad++;
      $display("FAIL %s op=%0d: res=%h flags=%b mask=%b expected res=%h flags=%b mask=%b",
               tag, op, res_o, flags_o, wmask_o, er, ef, em);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; op_i = 4'd11; opa_i = 8'h00; flags_i = 4'hF;
    @(posedge clk);
    #1;
    total++;
    if (res_o !== 8'h00 || flags_o !== 4'h0 || wmask_o !== 4'h0) begin
      bad++;
      $display("FAIL R10 reset: res=%h flags=%b mask=%b expected 00/0000/0000",
               res_o, flags_o, wmask_o);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add();
    run_op(4'd0, 8'h3A, 8'hC6, 4'b0000, 8'h00, 4'b1011, 4'b1111, "R1 add wrap");
    run_op(4'd0, 8'h12, 8'h34, 4'b0000, 8'h46, 4'b0000, 4'b1111, "R1 add plain");
    run_op(4'd1, 8'h0F, 8'h00, 4'b0001, 8'h10, 4'b0010, 4'b1111, "R1 adc nibble carry");
  endtask

  task automatic t_sub();
    run_op(4'd2, 8'h3E, 8'h3E, 4'b0000, 8'h00, 4'b1100, 4'b1111, "R2 sub zero");
    run_op(4'd2, 8'h3E, 8'h40, 4'b0000, 8'hFE, 4'b0101, 4'b1111, "R2 sub borrow");
    run_op(4'd3, 8'h3B, 8'h2A, 4'b0001, 8'h10, 4'b0100, 4'b1111, "R2 sbc");
    run_op(4'd3, 8'h10, 8'h0F, 4'b0001, 8'h00, 4'b1110, 4'b1111, "R2 sbc half borrow");
  endtask

  task automatic t_cmp();
    run_op(4'd7, 8'h3C, 8'h2F, 4'b0000, 8'h3C, 4'b0110, 4'b1111, "R3 cmp");
  endtask

  task automatic t_logic();
    run_op(4'd4, 8'h5A, 8'hA5, 4'b0000, 8'h00, 4'b1010, 4'b1111, "R4 and");
    run_op(4'd5, 8'h5A, 8'h00, 4'b1111, 8'h5A, 4'b0000, 4'b1111, "R4 or");
    run_op(4'd6, 8'hFF, 8'hFF, 4'b0000, 8'h00, 4'b1000, 4'b1111, "R4 xor");
  endtask

  task automatic t_incdec();
    run_op(4'd8, 8'h55, 8'hFF, 4'b0001, 8'h00, 4'b1011, 4'b1110, "R5 inc wrap keeps C");
    run_op(4'd9, 8'h55, 8'h01, 4'b0000, 8'h00, 4'b1100, 4'b1110, "R5 dec to zero");
    run_op(4'd9, 8'h55, 8'h10, 4'b0001, 8'h0F, 4'b0111, 4'b1110, "R5 dec half borrow");
  endtask

  task automatic t_daa();
    run_op(4'd10, 8'h3C, 8'h00, 4'b0000, 8'h42, 4'b0000, 4'b1011, "R6 daa low fix");
    run_op(4'd10, 8'h9A, 8'h00, 4'b0000, 8'h00, 4'b1001, 4'b1011, "R6 daa both fix");
    run_op(4'd10, 8'h2D, 8'h00, 4'b0110, 8'h27, 4'b0100, 4'b1011, "R6 daa after sub");
  endtask

  task automatic t_misc();
    run_op(4'd11, 8'h35, 8'h00, 4'b1001, 8'hCA, 4'b1111, 4'b0110, "R7 cpl");
    run_op(4'd12, 8'h21, 8'h00, 4'b1110, 8'h21, 4'b1001, 4'b0111, "R8 scf");
    run_op(4'd13, 8'h21, 8'h00, 4'b0001, 8'h21, 4'b0000, 4'b0111, "R8 ccf clear");
    run_op(4'd13, 8'h21, 8'h00, 4'b1000, 8'h21, 4'b1001, 4'b0111, "R8 ccf set");
  endtask

  task automatic t_pass();
    run_op(4'd15, 8'h77, 8'h12, 4'b0101, 8'h77, 4'b0101, 4'b0000, "R11 R9 pass code");
    run_op(4'd14, 8'h08, 8'hFF, 4'b1010, 8'h08, 4'b1010, 4'b0000, "R11 R9 pass code 14");
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_incdec();
    t_daa();
    t_misc();
    t_pass();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule